// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. The line is sampled on a tick that runs at sixteen times the bit rate. Three format inputs are read at run time: the character width (5 to 8 bits), whether a parity bit follows the data, and whether that parity is even or odd. Each finished character leaves the block as a one-cycle strobe. The strobe carries the data and three error tags for that character: parity, framing and break.

Alongside the per-character tags, the block keeps sticky line-status flags. A one-cycle read strobe clears them. One of these flags marks that the one-entry receive buffer has taken an erroneous character.

The receiver has two recovery rules. When a stop bit samples low, that low level is taken as the start bit of the next character, and reception goes on without waiting for a falling edge. When a frame is low from start to stop, it is reported as a break. The receiver then ignores the line until it goes back to the high (marking) level.

The serial input is assumed to be already synchronised to `clk`. Only the first stop bit is sampled, so the receiver needs no stop-count setting.

Top module: `uart_rx_line`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_data_o`, all three tags and all four status flags are 0.
- R2: A low level seen on a tick starts a frame only if the line is still low on the 8th tick after it. If the line is high at that point, the low pulse is discarded and no character is delivered.
- R3: Data arrives least significant bit first. `wlen_i` values 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Data bits above the selected width read as 0.
- R4: When `par_en_i` is 1, one parity bit follows the data. With `par_odd_i`=0, the data bits plus the parity bit must hold an even number of ones; with `par_odd_i`=1, an odd number. Otherwise `perr_tag_o` is 1 with the character.
- R5: A stop bit sampled low, in a frame that is not a break, delivers the data with `ferr_tag_o`=1.
- R6: After a framing error, the low stop bit serves as the start bit of the next character. That character is received with no new falling edge.
- R7: A frame whose start, data, parity (if enabled) and stop samples are all low is delivered as data 0 with `brk_tag_o`=1 and the parity and framing tags at 0. No further character is delivered until the line has been high for at least one tick.
- R8: Each frame yields exactly one `rx_valid_o` pulse, one cycle long. Data and tags are valid in that cycle.
- R9: `st_perr_o`, `st_ferr_o` and `st_brk_o` go to 1 in the cycle after a delivered character carries the matching tag. They stay set until a cycle in which `stat_rd_i` is 1. If a new tag arrives in that same cycle, setting wins over clearing.
- R10: `st_errbuf_o` goes to 1 in the cycle after a character carrying any error tag is loaded. It clears on `stat_rd_i` unless an erroneous character is loaded in that same cycle.
- R11: Bit timing advances only on cycles where `tick_i` is 1. Characters decode correctly when ticks arrive only every few clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| wlen_i | input | 2 | Character width code, 5 + value bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| stat_rd_i | input | 1 | Status read strobe, clears sticky flags |
| rx_valid_o | output | 1 | One-cycle character strobe |
| rx_data_o | output | DATA_W | Received character |
| perr_tag_o | output | 1 | Parity error for this character |
| ferr_tag_o | output | 1 | Framing error for this character |
| brk_tag_o | output | 1 | Break for this character |
| st_perr_o | output | 1 | Sticky parity error flag |
| st_ferr_o | output | 1 | Sticky framing error flag |
| st_brk_o | output | 1 | Sticky break flag |
| st_errbuf_o | output | 1 | Erroneous character in buffer |

## Verification
The bench builds the block with its defaults: DATA_W=8, so every width code from 5 to 8 bits can be exercised, and OVS=16, so each bit lasts 16 ticks and the start check falls on the 8th tick. The bench drives the tick on every cycle for most scenarios and on every third cycle for one scenario. This covers both the case where the tick gates every state change and the case where it is always present. The stimuli include a glitch shorter than half a bit, a bad stop bit followed straight away by the next character, and a break held well past its frame.

// File: rtl/rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: the character width code is two bits and means 5 + code bits.
package rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_tags_t;

    // Number of data bits selected by a width code.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/rx_parity.sv
// Parity checker for one received character.
// Assumes: data bits above the active width are already zero.
module rx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic          pbit_i,
    input  logic          odd_i,
    output logic          fail_o
);

    // Even parity fails on an odd total count; odd parity fails on an even one.
    always_comb fail_o = (^data_i) ^ pbit_i ^ odd_i;

endmodule

// File: rtl/rx_frame.sv
// Bit-level receive engine: start confirmation, data, parity and stop sampling,
// framing resync and break lockout. Emits one registered strobe per frame.
// Assumes: rx_i is synchronous to clk; tick_i pulses OVS times per bit.
module rx_frame
    import rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    input  logic          tick_i,
    input  logic [1:0]    wlen_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output rx_tags_t      tags_o
);

    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e      state;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  idx;
    logic [IW-1:0]  last_idx;
    logic [DW-1:0]  data_q;
    logic           pbit_q;
    logic           par_fail;
    logic           all_low;
    logic           valid_q;
    logic [DW-1:0]  dout_q;
    rx_tags_t       tags_q;

    rx_parity #(.DW(DW)) u_par (
        .data_i (data_q),
        .pbit_i (pbit_q),
        .odd_i  (par_odd_i),
        .fail_o (par_fail)
    );

    // Index of the final data bit for the selected width.
    always_comb last_idx = IW'(char_bits(wlen_i) - 4'd1);

    // All sampled data and parity levels low (start and stop checked by caller).
    always_comb all_low = (data_q == '0) && (!par_en_i || !pbit_q);

    // Frame state machine, advanced only on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            data_q  <= '0;
            pbit_q  <= 1'b0;
            valid_q <= 1'b0;
            dout_q  <= '0;
            tags_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (tick_i) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_i) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rx_i) begin
                                state  <= ST_DATA;
                                idx    <= '0;
                                data_q <= '0;
                                pbit_q <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            data_q[idx] <= rx_i;
                            if (idx == last_idx) begin
                                state <= par_en_i ? ST_PAR : ST_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            pbit_q <= rx_i;
                            state  <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            valid_q <= 1'b1;
                            if (!rx_i && all_low) begin
                                dout_q <= '0;
                                tags_q <= '{perr: 1'b0, ferr: 1'b0, brk: 1'b1};
                                state  <= ST_HOLD;
                            end else if (!rx_i) begin
                                dout_q <= data_q;
                                tags_q <= '{perr: par_en_i & par_fail, ferr: 1'b1, brk: 1'b0};
                                state  <= ST_DATA;
                                idx    <= '0;
                                data_q <= '0;
                                pbit_q <= 1'b0;
                            end else begin
                                dout_q <= data_q;
                                tags_q <= '{perr: par_en_i & par_fail, ferr: 1'b0, brk: 1'b0};
                                state  <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (rx_i) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = dout_q;
    assign tags_o  = tags_q;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7
    hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rx_i) |=> (state == ST_HOLD && !valid_q));

    // R7
    brk_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && tags_q.brk) |-> (dout_q == '0 && !tags_q.ferr && !tags_q.perr));

    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && wlen_i == 2'b00) |-> ((dout_q >> 5) == '0));

    // R11
    no_tick_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(state) && $stable(cnt)));

endmodule

// File: rtl/rx_status.sv
// Sticky line-status flags over a one-entry receive buffer.
// Assumes: load_i is a one-cycle strobe with tags valid in the same cycle.
module rx_status
    import rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  rx_tags_t tags_i,
    input  logic     rd_i,
    output logic     st_perr_o,
    output logic     st_ferr_o,
    output logic     st_brk_o,
    output logic     st_errbuf_o
);

    logic bad_load;

    // Any error tag on the character entering the buffer.
    always_comb bad_load = load_i & (tags_i.perr | tags_i.ferr | tags_i.brk);

    // Flags set on a tagged load and clear on read; setting takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_perr_o   <= 1'b0;
            st_ferr_o   <= 1'b0;
            st_brk_o    <= 1'b0;
            st_errbuf_o <= 1'b0;
        end else begin
            st_perr_o   <= (st_perr_o   & ~rd_i) | (load_i & tags_i.perr);
            st_ferr_o   <= (st_ferr_o   & ~rd_i) | (load_i & tags_i.ferr);
            st_brk_o    <= (st_brk_o    & ~rd_i) | (load_i & tags_i.brk);
            st_errbuf_o <= (st_errbuf_o & ~rd_i) | bad_load;
        end
    end

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> (!st_perr_o && !st_ferr_o && !st_brk_o && !st_errbuf_o));

    // R9
    ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tags_i.ferr) |=> st_ferr_o);

    // R10
    errbuf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_load |=> st_errbuf_o);

endmodule

// File: rtl/uart_rx_line.sv
// Top level: serial receiver with per-character error tags and sticky status.
// Assumes: DATA_W is 8 so every width code fits; rx_i is already synchronised.
module uart_rx_line
    import rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic [1:0]        wlen_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              stat_rd_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              perr_tag_o,
    output logic              ferr_tag_o,
    output logic              brk_tag_o,
    output logic              st_perr_o,
    output logic              st_ferr_o,
    output logic              st_brk_o,
    output logic              st_errbuf_o
);

    rx_tags_t tags;
    logic     valid;

    rx_frame #(.DW(DATA_W), .OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .tick_i    (tick_i),
        .wlen_i    (wlen_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .valid_o   (valid),
        .data_o    (rx_data_o),
        .tags_o    (tags)
    );

    rx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (valid),
        .tags_i      (tags),
        .rd_i        (stat_rd_i),
        .st_perr_o   (st_perr_o),
        .st_ferr_o   (st_ferr_o),
        .st_brk_o    (st_brk_o),
        .st_errbuf_o (st_errbuf_o)
    );

    assign rx_valid_o = valid;
    assign perr_tag_o = tags.perr;
    assign ferr_tag_o = tags.ferr;
    assign brk_tag_o  = tags.brk;

endmodule

// File: tb/sim_uart_rx_line.sv
module sim_uart_rx_line;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stat_rd = 1'b0;
    logic       valid;
    logic [7:0] data;
    logic       perr_t, ferr_t, brk_t;
    logic       s_perr, s_ferr, s_brk, s_ebuf;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv = 1;
    int tcnt = 0;
    int nv = 0;
    int cap_d [64];
    int cap_p [64];
    int cap_f [64];
    int cap_b [64];

    uart_rx_line u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .wlen_i(wlen),
        .par_en_i(par_en), .par_odd_i(par_odd), .stat_rd_i(stat_rd),
        .rx_valid_o(valid), .rx_data_o(data), .perr_tag_o(perr_t),
        .ferr_tag_o(ferr_t), .brk_tag_o(brk_t), .st_perr_o(s_perr),
        .st_ferr_o(s_ferr), .st_brk_o(s_brk), .st_errbuf_o(s_ebuf)
    );

    always #4 clk = ~clk;

    // Tick generator: one tick every tdiv cycles, changed just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tcnt = tcnt + 1;
            tick = ((tcnt % tdiv) == 0);
        end
    end

    // Capture every delivered character away from the active edge.
    always @(negedge clk) begin
        if (valid && nv < 64) begin
            cap_d[nv] = int'(data);
            cap_p[nv] = int'(perr_t);
            cap_f[nv] = int'(ferr_t);
            cap_b[nv] = int'(brk_t);
            nv = nv + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_ticks(input int n);
        repeat (n * tdiv) @(posedge clk);
        #2;
    endtask

    task automatic drive_bit(input logic v);
        rx = v;
        hold_ticks(16);
    endtask

    // Sends optional start, nb data bits LSB first, optional parity, one stop.
    task automatic send_char(input logic [7:0] d, input int nb, input bit with_start,
                             input bit use_par, input logic pbit, input logic stopv);
        if (with_start) drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (use_par) drive_bit(pbit);
        drive_bit(stopv);
    endtask

    task automatic idle_line(input int n);
        rx = 1'b1;
        hold_ticks(n);
    endtask

    task automatic pulse_read();
        @(posedge clk); #2;
        stat_rd = 1'b1;
        @(posedge clk); #2;
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_char(input int k, input string req, input int d,
                               input int p, input int f, input int b);
        check(cap_d[k] == d, req, cap_d[k], d);
        check(cap_p[k] == p && cap_f[k] == f && cap_b[k] == b, req,
              cap_p[k] * 4 + cap_f[k] * 2 + cap_b[k], p * 4 + f * 2 + b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(valid == 1'b0 && data == 8'h00, "R1", {valid, data}, 0);
        check({perr_t, ferr_t, brk_t, s_perr, s_ferr, s_brk, s_ebuf} == 7'b0, "R1",
              {perr_t, ferr_t, brk_t, s_perr, s_ferr, s_brk, s_ebuf}, 0);
    endtask

    task automatic t_basic();
        int n0 = nv;
        wlen = 2'b11; par_en = 1'b0;
        send_char(8'hA5, 8, 1, 0, 0, 1); idle_line(4);
        send_char(8'h3C, 8, 1, 0, 0, 1); idle_line(4);
        check(nv == n0 + 2, "R8", nv - n0, 2);
        expect_char(n0, "R3", 'hA5, 0, 0, 0);
        expect_char(n0 + 1, "R3", 'h3C, 0, 0, 0);
        check(s_ebuf == 1'b0 && s_ferr == 1'b0, "R9", {s_ebuf, s_ferr}, 0);
    endtask

    task automatic t_width();
        int n0 = nv;
        wlen = 2'b00;
        send_char(8'hF5, 5, 1, 0, 0, 1); idle_line(4);
        wlen = 2'b01;
        send_char(8'hEA, 6, 1, 0, 0, 1); idle_line(4);
        wlen = 2'b10;
        send_char(8'hD3, 7, 1, 0, 0, 1); idle_line(4);
        wlen = 2'b11;
        check(nv == n0 + 3, "R3", nv - n0, 3);
        expect_char(n0, "R3", 'h15, 0, 0, 0);
        expect_char(n0 + 1, "R3", 'h2A, 0, 0, 0);
        expect_char(n0 + 2, "R3", 'h53, 0, 0, 0);
    endtask

    task automatic t_glitch();
        int n0 = nv;
        rx = 1'b0; hold_ticks(4);
        idle_line(40);
        check(nv == n0, "R2", nv - n0, 0);
        send_char(8'h81, 8, 1, 0, 0, 1); idle_line(4);
        check(nv == n0 + 1, "R2", nv - n0, 1);
        expect_char(n0, "R2", 'h81, 0, 0, 0);
    endtask

    task automatic t_parity();
        int n0 = nv;
        par_en = 1'b1; par_odd = 1'b0;
        send_char(8'h07, 8, 1, 1, ^8'h07, 1); idle_line(4);
        send_char(8'h07, 8, 1, 1, ~^8'h07, 1); idle_line(4);
        par_odd = 1'b1;
        send_char(8'h0F, 8, 1, 1, ~^8'h0F, 1); idle_line(4);
        send_char(8'h0F, 8, 1, 1, ^8'h0F, 1); idle_line(4);
        check(nv == n0 + 4, "R4", nv - n0, 4);
        expect_char(n0, "R4", 'h07, 0, 0, 0);
        expect_char(n0 + 1, "R4", 'h07, 1, 0, 0);
        expect_char(n0 + 2, "R4", 'h0F, 0, 0, 0);
        expect_char(n0 + 3, "R4", 'h0F, 1, 0, 0);
        check(s_perr == 1'b1 && s_ebuf == 1'b1, "R9", {s_perr, s_ebuf}, 3);
        pulse_read();
        check(s_perr == 1'b0 && s_ebuf == 1'b0, "R10", {s_perr, s_ebuf}, 0);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_frame_resync();
        int n0 = nv;
        send_char(8'h96, 8, 1, 0, 0, 0);
        send_char(8'h3C, 8, 0, 0, 0, 1); idle_line(4);
        check(nv == n0 + 2, "R6", nv - n0, 2);
        expect_char(n0, "R5", 'h96, 0, 1, 0);
        expect_char(n0 + 1, "R6", 'h3C, 0, 0, 0);
        check(s_ferr == 1'b1 && s_ebuf == 1'b1, "R9", {s_ferr, s_ebuf}, 3);
        check(s_brk == 1'b0 && s_perr == 1'b0, "R9", {s_brk, s_perr}, 0);
        pulse_read();
        check(s_ferr == 1'b0 && s_ebuf == 1'b0, "R10", {s_ferr, s_ebuf}, 0);
    endtask

    task automatic t_break();
        int n0 = nv;
        par_en = 1'b1; par_odd = 1'b1;
        rx = 1'b0; hold_ticks(16 * 11 + 80);
        check(nv == n0 + 1, "R7", nv - n0, 1);
        expect_char(n0, "R7", 0, 0, 0, 1);
        check(s_brk == 1'b1 && s_ebuf == 1'b1, "R9", {s_brk, s_ebuf}, 3);
        idle_line(4);
        send_char(8'h5A, 8, 1, 1, ~^8'h5A, 1); idle_line(4);
        check(nv == n0 + 2, "R7", nv - n0, 2);
        expect_char(n0 + 1, "R7", 'h5A, 0, 0, 0);
        check(s_brk == 1'b1, "R9", s_brk, 1);
        pulse_read();
        check(s_brk == 1'b0 && s_ebuf == 1'b0, "R10", {s_brk, s_ebuf}, 0);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_slow_tick();
        int n0 = nv;
        tdiv = 3;
        idle_line(4);
        send_char(8'hC3, 8, 1, 0, 0, 1); idle_line(4);
        send_char(8'h18, 8, 1, 0, 0, 0); idle_line(4);
        check(nv == n0 + 2, "R11", nv - n0, 2);
        expect_char(n0, "R11", 'hC3, 0, 0, 0);
        expect_char(n0 + 1, "R11", 'h18, 0, 1, 0);
        tdiv = 1;
        pulse_read();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        idle_line(4);
        t_basic();
        t_width();
        t_glitch();
        t_parity();
        t_frame_resync();
        t_break();
        t_slow_tick();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule